// File: doc/BRIEF.md
# Register bit test/modify unit

This execute-stage unit performs single-bit work on a 32-bit register word and on the two processor flags, carry (C) and zero (Z). Each clock it takes one decoded instruction: a 3-bit operation field, the two flag-effect bits, a select between an immediate and a register source operand, the destination register value, the current flags, a condition-pass input and a random bit. One clock edge later it presents the new register word with its write enable and the new flags with their write enables.

The flag-effect bits choose between two families that share the operation field. With exactly one effect bit set, the instruction tests a register bit and folds it into that one flag. With both or neither set, it writes a bit of the register, and with both set it also returns the bit's previous value as C and its inverse as Z. A false condition input cancels the instruction. Because of this, a conditional clear, set or invert acts as AND, OR or XOR of the bit with a flag, so no separate combine-into-bit operations are needed.

Top module: `bitop_unit`

## Requirements
- R1: The instruction is a test when exactly one of `c_eff_i` and `z_eff_i` is high, and a bit write when both or neither are high; `op_i` selects the operation inside either family.
- R2: In a test, `op_i[0]` inverts the tested bit first, and `op_i[2:1]` combines it with the chosen flag: 00 replaces the flag, 01 ANDs, 10 ORs, 11 XORs.
- R3: A test raises only the write enable of the flag whose effect bit is set, drives that flag with the combined value, and keeps `reg_we_o` low with `result_o` equal to the destination word.
- R4: A bit write raises `reg_we_o` and replaces the indexed bit by, for `op_i` 0 to 7: 0, 1, C, !C, Z, !Z, `rnd_i`, the inverted old bit; all other bits keep their destination values.
- R5: A bit write with both effect bits high raises both flag write enables, with `c_o` equal to the bit's value before the write and `z_o` its inverse; with neither high, both flag write enables stay low.
- R6: The bit index is the low 5 bits of `src_imm_i` when `imm_sel_i` is 1 and of `src_reg_i` when it is 0; all higher source bits are ignored.
- R7: When `cond_i` is low, all three write enables stay low and `result_o` equals the destination word.
- R8: Outputs are registered: they reflect the inputs of the previous clock edge, and reset clears every output to 0. A flag whose write enable is low is presented at its input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation field |
| c_eff_i | input | 1 | Carry effect bit |
| z_eff_i | input | 1 | Zero effect bit |
| imm_sel_i | input | 1 | 1 selects the immediate as bit index source |
| src_imm_i | input | 9 | Immediate source operand |
| src_reg_i | input | 32 | Register source operand |
| dst_i | input | 32 | Destination register value |
| c_i | input | 1 | Current carry flag |
| z_i | input | 1 | Current zero flag |
| cond_i | input | 1 | Condition pass |
| rnd_i | input | 1 | Random bit |
| result_o | output | 32 | New destination word |
| reg_we_o | output | 1 | Destination write enable |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |
| c_we_o | output | 1 | Carry write enable |
| z_we_o | output | 1 | Zero write enable |

## Verification
The unit holds no state beyond its output register, so a wrong decode, a wrong index or a wrong combine shows at the ports exactly one clock after the offending instruction and never lingers past the next one. A misrouted family appears as a register write enable where a flag update was due, or the reverse; a wrong index appears as a change in a bit other than the selected one, or as a flag fed from the wrong bit. Sweeping every operation against every effect-bit pairing, both flag values, both condition values, both index sources and the edge indices 0 and 31 brings each such fault out in the cycle after it is issued.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    CMB_SET = 2'b00,
    CMB_AND = 2'b01,
    CMB_OR  = 2'b10,
    CMB_XOR = 2'b11
  } combine_e;

  typedef enum logic [2:0] {
    WR_LOW  = 3'd0,
    WR_HIGH = 3'd1,
    WR_C    = 3'd2,
    WR_NC   = 3'd3,
    WR_Z    = 3'd4,
    WR_NZ   = 3'd5,
    WR_RND  = 3'd6,
    WR_NOT  = 3'd7
  } wr_src_e;
endpackage

// File: rtl/bitop_index_sel.sv
module bitop_index_sel #(
  parameter int SRC_W = 32,
  parameter int IMM_W = 9,
  parameter int IDX_W = 5
) (
  input  logic             imm_sel_i,
  input  logic [IMM_W-1:0] src_imm_i,
  input  logic [SRC_W-1:0] src_reg_i,
  output logic [IDX_W-1:0] idx_o
);
  // upper operand bits carry no meaning here
  logic unused_src_hi;
  assign unused_src_hi = ^{src_imm_i[IMM_W-1:IDX_W], src_reg_i[SRC_W-1:IDX_W]};

  assign idx_o = imm_sel_i ? src_imm_i[IDX_W-1:0] : src_reg_i[IDX_W-1:0];
endmodule

// File: rtl/bitop_flag_path.sv
module bitop_flag_path
  import bitop_pkg::*;
(
  input  logic [2:0] op_i,
  input  logic       bit_i,
  input  logic       flag_i,
  output logic       flag_o
);
  logic     tb;
  combine_e cmb;

  assign tb  = bit_i ^ op_i[0];
  assign cmb = combine_e'(op_i[2:1]);

  always_comb begin
    unique case (cmb)
      CMB_SET: flag_o = tb;
      CMB_AND: flag_o = flag_i & tb;
      CMB_OR:  flag_o = flag_i | tb;
      default: flag_o = flag_i ^ tb;
    endcase
  end
endmodule

// File: rtl/bitop_bit_write.sv
module bitop_bit_write
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              rnd_i,
  output logic              old_o,
  output logic [DATA_W-1:0] word_o
);
  logic    new_bit;
  wr_src_e src;

  assign old_o = word_i[idx_i];
  assign src   = wr_src_e'(op_i);

  always_comb begin
    unique case (src)
      WR_LOW:  new_bit = 1'b0;
      WR_HIGH: new_bit = 1'b1;
      WR_C:    new_bit = c_i;
      WR_NC:   new_bit = ~c_i;
      WR_Z:    new_bit = z_i;
      WR_NZ:   new_bit = ~z_i;
      WR_RND:  new_bit = rnd_i;
      default: new_bit = ~old_o;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_ins
    assign word_o[i] = (idx_i == IDX_W'(i)) ? new_bit : word_i[i];
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 9,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic              c_eff_i,
  input  logic              z_eff_i,
  input  logic              imm_sel_i,
  input  logic [IMM_W-1:0]  src_imm_i,
  input  logic [DATA_W-1:0] src_reg_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              c_i,
  input  logic              z_i,
  input  logic              cond_i,
  input  logic              rnd_i,
  output logic [DATA_W-1:0] result_o,
  output logic              reg_we_o,
  output logic              c_o,
  output logic              z_o,
  output logic              c_we_o,
  output logic              z_we_o
);
  logic [IDX_W-1:0]  idx;
  logic              old_bit;
  logic [DATA_W-1:0] wr_word;
  logic              tgt_flag, cmb_flag;
  logic              is_test, is_wpcz;

  logic [DATA_W-1:0] res_d;
  logic              rwe_d, c_d, z_d, cwe_d, zwe_d;

  bitop_index_sel #(.SRC_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_idx (
    .imm_sel_i (imm_sel_i),
    .src_imm_i (src_imm_i),
    .src_reg_i (src_reg_i),
    .idx_o     (idx)
  );

  bitop_bit_write #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wr (
    .op_i   (op_i),
    .idx_i  (idx),
    .word_i (dst_i),
    .c_i    (c_i),
    .z_i    (z_i),
    .rnd_i  (rnd_i),
    .old_o  (old_bit),
    .word_o (wr_word)
  );

  assign tgt_flag = c_eff_i ? c_i : z_i;

  bitop_flag_path u_flag (
    .op_i   (op_i),
    .bit_i  (old_bit),
    .flag_i (tgt_flag),
    .flag_o (cmb_flag)
  );

  assign is_test = c_eff_i ^ z_eff_i;
  assign is_wpcz = c_eff_i & z_eff_i;

  always_comb begin
    res_d = dst_i;
    rwe_d = 1'b0;
    c_d   = c_i;
    z_d   = z_i;
    cwe_d = 1'b0;
    zwe_d = 1'b0;
    if (cond_i) begin
      if (is_test) begin
        cwe_d = c_eff_i;
        zwe_d = z_eff_i;
        if (c_eff_i) c_d = cmb_flag;
        else         z_d = cmb_flag;
      end else begin
        res_d = wr_word;
        rwe_d = 1'b1;
        if (is_wpcz) begin
          // old bit sampled before the write edge
          c_d   = old_bit;
          z_d   = ~old_bit;
          cwe_d = 1'b1;
          zwe_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      reg_we_o <= 1'b0;
      c_o      <= 1'b0;
      z_o      <= 1'b0;
      c_we_o   <= 1'b0;
      z_we_o   <= 1'b0;
    end else begin
      result_o <= res_d;
      reg_we_o <= rwe_d;
      c_o      <= c_d;
      z_o      <= z_d;
      c_we_o   <= cwe_d;
      z_we_o   <= zwe_d;
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              c_eff_i,
  input logic              z_eff_i,
  input logic [DATA_W-1:0] dst_i,
  input logic              c_i,
  input logic              cond_i,
  input logic [DATA_W-1:0] result_o,
  input logic              reg_we_o,
  input logic              c_o,
  input logic              z_o,
  input logic              c_we_o,
  input logic              z_we_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_test_no_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cond_i && (c_eff_i ^ z_eff_i)) |-> !reg_we_o && result_o == $past(dst_i));

  p_test_one_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cond_i && (c_eff_i ^ z_eff_i)) |->
      c_we_o == $past(c_eff_i) && z_we_o == $past(z_eff_i));

  p_cond_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(cond_i) |->
      !reg_we_o && !c_we_o && !z_we_o && result_o == $past(dst_i));

  p_wr_one_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cond_i && !(c_eff_i ^ z_eff_i)) |->
      reg_we_o && $countones(result_o ^ $past(dst_i)) <= 1);

  p_wpcz_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(cond_i && c_eff_i && z_eff_i) |-> c_we_o && z_we_o && (z_o != c_o));

  p_no_eff_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!c_eff_i && !z_eff_i) |-> !c_we_o && !z_we_o);

  p_carry_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !c_we_o |-> c_o == $past(c_i));
endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .c_eff_i  (c_eff_i),
  .z_eff_i  (z_eff_i),
  .dst_i    (dst_i),
  .c_i      (c_i),
  .cond_i   (cond_i),
  .result_o (result_o),
  .reg_we_o (reg_we_o),
  .c_o      (c_o),
  .z_o      (z_o),
  .c_we_o   (c_we_o),
  .z_we_o   (z_we_o)
);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = '0;
  logic        c_eff_i = 1'b0, z_eff_i = 1'b0, imm_sel_i = 1'b0;
  logic [8:0]  src_imm_i = '0;
  logic [31:0] src_reg_i = '0, dst_i = '0;
  logic        c_i = 1'b0, z_i = 1'b0, cond_i = 1'b0, rnd_i = 1'b0;
  logic [31:0] result_o;
  logic        reg_we_o, c_o, z_o, c_we_o, z_we_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  logic [31:0] e_res;
  logic        e_rwe, e_c, e_z, e_cwe, e_zwe;
  logic        have_exp = 1'b0;
  string       tag_w, tag_f;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bitop_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .c_eff_i(c_eff_i), .z_eff_i(z_eff_i),
    .imm_sel_i(imm_sel_i), .src_imm_i(src_imm_i), .src_reg_i(src_reg_i), .dst_i(dst_i),
    .c_i(c_i), .z_i(z_i), .cond_i(cond_i), .rnd_i(rnd_i), .result_o(result_o),
    .reg_we_o(reg_we_o), .c_o(c_o), .z_o(z_o), .c_we_o(c_we_o), .z_we_o(z_we_o)
  );

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of the requirements
  task automatic model();
    int  ix;
    logic old, b, f;
    ix    = imm_sel_i ? int'(src_imm_i) % 32 : int'(src_reg_i % 32);  // R6
    old   = dst_i[ix];
    e_res = dst_i; e_rwe = 0; e_c = c_i; e_z = z_i; e_cwe = 0; e_zwe = 0;
    if (!cond_i) begin
      tag_w = "R7"; tag_f = "R7 R8";
    end else if (c_eff_i != z_eff_i) begin  // R1 test family
      tag_w = "R1 R3"; tag_f = "R2 R3 R6";
      b = op_i[0] ? !old : old;
      f = c_eff_i ? c_i : z_i;
      case (op_i / 2)
        0: f = b;
        1: f = f & b;
        2: f = f | b;
        default: f = f ^ b;
      endcase
      if (c_eff_i) begin e_c = f; e_cwe = 1; end
      else         begin e_z = f; e_zwe = 1; end
    end else begin
      tag_w = "R1 R4 R6"; tag_f = "R5 R8";
      case (op_i)
        0: b = 0;
        1: b = 1;
        2: b = c_i;
        3: b = !c_i;
        4: b = z_i;
        5: b = !z_i;
        6: b = rnd_i;
        default: b = !old;
      endcase
      e_res[ix] = b; e_rwe = 1;
      if (c_eff_i) begin e_c = old; e_z = !old; e_cwe = 1; e_zwe = 1; end
    end
  endtask

  task automatic compare();
    if (have_exp) begin
      check(tag_w, {3'b0, reg_we_o, result_o}, {3'b0, e_rwe, e_res});
      check(tag_f, {32'b0, c_we_o, z_we_o, c_o, z_o}, {32'b0, e_cwe, e_zwe, e_c, e_z});
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R8 watchdog actual=%0d expected<=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R8 reset state
    check("R8", {reg_we_o, c_o, z_o, result_o, c_we_o}, 36'h0);
    check("R8", {35'b0, z_we_o}, 36'h0);
    rst_ni = 1'b1;
    for (int op = 0; op < 8; op++)
      for (int ef = 0; ef < 4; ef++)
        for (int k = 0; k < 3; k++)
          for (int cz = 0; cz < 4; cz++)
            for (int cd = 0; cd < 2; cd++)
              for (int sl = 0; sl < 2; sl++) begin
                logic [4:0] ix;
                @(negedge clk_i);
                compare();
                lfsr = step(lfsr); dst_i = lfsr;
                lfsr = step(lfsr);
                ix = (k == 0) ? 5'd0 : (k == 1) ? 5'd31 : lfsr[4:0];
                op_i = 3'(op); c_eff_i = ef[1]; z_eff_i = ef[0];
                c_i = cz[1]; z_i = cz[0]; cond_i = cd[0]; imm_sel_i = sl[0];
                rnd_i = lfsr[7];
                lfsr = step(lfsr);
                // R6: junk above the index in both operands
                if (sl != 0) begin
                  src_imm_i = {lfsr[12:9], ix};
                  src_reg_i = step(lfsr);
                end else begin
                  src_reg_i = {lfsr[31:5], ix};
                  src_imm_i = step(lfsr)[8:0];
                end
                model();
                have_exp = 1'b1;
              end
    @(negedge clk_i);
    compare();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule